// File: doc/BRIEF.md
# Per-Thread Deadline Timer Unit

This unit holds one down-counting timer for every hardware thread of an interleaved pipeline. A thread uses it to make a block of code last exactly a required number of cycles. When the thread reaches the end of the block it issues a wait-style deadline instruction. While its timer is still above zero, the unit asserts `stall` in that same cycle and the pipeline replays the instruction. In the first cycle the timer reads zero, the instruction completes and reloads the timer with the value it carries. This starts the budget for the next block.

Two further instruction kinds exist. The branch-on-miss kind never stalls and always reloads the timer. If the timer had already reached zero when this kind issued, the budget was overrun, and the unit pulses `miss_valid` with the thread number one cycle later so that the pipeline can redirect the thread to a handler. The plain load kind sets the timer without waiting and without any miss report. All timers count down by one every cycle and stop at zero.

Top module: `deadline_timer_unit`

## Requirements
- R1: Reset clears every timer to zero. After reset, `stall` and `miss_valid` are low, and the first wait instruction on any thread completes without stalling.
- R2: A wait instruction (`issue_kind` = 0) asserts `stall` combinationally in every cycle in which its thread's timer is non-zero. When the instruction is re-issued each cycle, it stalls for exactly the number of cycles remaining on the timer.
- R3: A wait instruction that meets a zero timer does not stall, and it loads `issue_value` into the timer at that clock edge.
- R4: Every timer that is not being loaded decreases by one per cycle, independently of the other threads and of instructions aimed at other threads.
- R5: A timer at zero stays at zero and never wraps.
- R6: A branch-on-miss instruction (`issue_kind` = 1) that meets a zero timer raises `miss_valid` one cycle later, with `miss_tid` equal to the issuing thread. The instruction also loads `issue_value`.
- R7: A branch-on-miss instruction that meets a non-zero timer neither stalls nor reports a miss, and it replaces the remaining count with `issue_value`.
- R8: A load instruction (`issue_kind` = 2) writes `issue_value` into the timer at once. It never stalls and never reports a miss.
- R9: Kind code 3 is reserved. It has no effect on any timer, on `stall` or on `miss_valid`.
- R10: `miss_valid` is a single-cycle pulse for each missing instruction. It is low in the cycle after the pulse unless another miss is issued.
- R11: An instruction whose `issue_tid` is not below the thread count has no effect, and at most one timer is written in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_valid | input | 1 | A deadline-type instruction is issued this cycle |
| issue_tid | input | 3 | Issuing thread number |
| issue_kind | input | 2 | 0 wait, 1 branch-on-miss, 2 load, 3 reserved |
| issue_value | input | 32 | New timer value carried by the instruction |
| stall | output | 1 | Issuing wait instruction must be replayed |
| miss_valid | output | 1 | One-cycle pulse: a deadline was missed |
| miss_tid | output | 3 | Thread that missed, valid with `miss_valid` |

## Verification
`stall` is combinational and is due in the issue cycle. The bench samples it 1 ns after driving the inputs on the falling edge, before the next rising edge. A timer write takes effect at the rising edge that ends the issue cycle, and `miss_valid` is registered once, so a miss shows up at the falling edge one cycle after the issue. The bench checks it there and checks the pulse has cleared one falling edge later. Remaining counts are never read directly. The bench keeps, per thread, the last loaded value and the cycle it took effect, and it predicts the number of stalled replays of a wait instruction from the free-running cycle counter.

// File: rtl/dtu_pkg.sv
package dtu_pkg;

  typedef enum logic [1:0] {
    KIND_WAIT   = 2'd0,
    KIND_BRANCH = 2'd1,
    KIND_LOAD   = 2'd2,
    KIND_RSVD   = 2'd3
  } dtu_kind_e;

endpackage

// File: rtl/dtu_timer_cell.sv
module dtu_timer_cell #(
  parameter int TIMER_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_en,
  input  logic [TIMER_W-1:0] load_val,
  output logic [TIMER_W-1:0] count,
  output logic               is_zero
);

  logic [TIMER_W-1:0] count_q;
  logic [TIMER_W-1:0] count_d;
  logic               count_en;

  assign is_zero = (count_q == '0);

  // next state: load overrides, otherwise step down and hold at zero
  always_comb begin
    count_en = load_en || !is_zero;
    if (load_en) begin
      count_d = load_val;
    end else if (!is_zero) begin
      count_d = count_q - TIMER_W'(1);
    end else begin
      count_d = count_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (count_en) begin
      count_q <= count_d;
    end
  end

  assign count = count_q;

endmodule

// File: rtl/dtu_issue_decode.sv
module dtu_issue_decode
  import dtu_pkg::*;
#(
  parameter int THREADS = 6,
  parameter int TID_W   = 3
) (
  input  logic               issue_valid,
  input  logic [TID_W-1:0]   issue_tid,
  input  logic [1:0]         issue_kind,
  input  logic [THREADS-1:0] zero_vec,
  output logic               stall,
  output logic               miss_hit,
  output logic [THREADS-1:0] load_vec
);

  localparam int SLOTS = 1 << TID_W;

  logic [SLOTS-1:0] zero_pad;
  logic             tid_ok;
  logic             act;
  logic             sel_zero;
  logic             do_load;
  dtu_kind_e        kind;

  // unused slots read as zero so they never stall; they are gated by tid_ok anyway
  for (genvar s = 0; s < SLOTS; s++) begin : g_pad
    if (s < THREADS) begin : g_real
      assign zero_pad[s] = zero_vec[s];
    end else begin : g_spare
      assign zero_pad[s] = 1'b1;
    end
  end

  assign kind     = dtu_kind_e'(issue_kind);
  assign tid_ok   = (int'(issue_tid) < THREADS);
  assign act      = issue_valid && tid_ok;
  assign sel_zero = zero_pad[issue_tid];

  always_comb begin
    stall    = 1'b0;
    miss_hit = 1'b0;
    do_load  = 1'b0;
    unique case (kind)
      KIND_WAIT: begin
        stall   = act && !sel_zero;
        do_load = act && sel_zero;
      end
      KIND_BRANCH: begin
        do_load  = act;
        miss_hit = act && sel_zero;
      end
      KIND_LOAD: begin
        do_load = act;
      end
      default: begin
        do_load = 1'b0;
      end
    endcase
  end

  always_comb begin
    for (int t = 0; t < THREADS; t++) begin
      load_vec[t] = do_load && (issue_tid == TID_W'(t));
    end
  end

endmodule

// File: rtl/dtu_miss_reg.sv
module dtu_miss_reg #(
  parameter int TID_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             miss_hit,
  input  logic [TID_W-1:0] hit_tid,
  output logic             miss_valid,
  output logic [TID_W-1:0] miss_tid
);

  logic             valid_q;
  logic [TID_W-1:0] tid_q;
  logic [TID_W-1:0] tid_d;
  logic             tid_en;

  always_comb begin
    tid_en = miss_hit;
    tid_d  = hit_tid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      tid_q   <= '0;
    end else begin
      valid_q <= miss_hit;
      if (tid_en) begin
        tid_q <= tid_d;
      end
    end
  end

  assign miss_valid = valid_q;
  assign miss_tid   = tid_q;

endmodule

// File: rtl/deadline_timer_unit.sv
module deadline_timer_unit #(
  parameter  int THREADS = 6,
  parameter  int TIMER_W = 32,
  localparam int TID_W   = (THREADS < 2) ? 1 : $clog2(THREADS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               issue_valid,
  input  logic [TID_W-1:0]   issue_tid,
  input  logic [1:0]         issue_kind,
  input  logic [TIMER_W-1:0] issue_value,
  output logic               stall,
  output logic               miss_valid,
  output logic [TID_W-1:0]   miss_tid
);

  logic [THREADS-1:0]         zero_vec;
  logic [THREADS-1:0]         load_vec;
  logic [THREADS*TIMER_W-1:0] timer_flat;
  logic                       miss_hit;

  dtu_issue_decode #(
    .THREADS (THREADS),
    .TID_W   (TID_W)
  ) u_decode (
    .issue_valid (issue_valid),
    .issue_tid   (issue_tid),
    .issue_kind  (issue_kind),
    .zero_vec    (zero_vec),
    .stall       (stall),
    .miss_hit    (miss_hit),
    .load_vec    (load_vec)
  );

  for (genvar t = 0; t < THREADS; t++) begin : g_thread
    dtu_timer_cell #(
      .TIMER_W (TIMER_W)
    ) u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_en  (load_vec[t]),
      .load_val (issue_value),
      .count    (timer_flat[t*TIMER_W +: TIMER_W]),
      .is_zero  (zero_vec[t])
    );
  end

  dtu_miss_reg #(
    .TID_W (TID_W)
  ) u_miss (
    .clk        (clk),
    .rst_n      (rst_n),
    .miss_hit   (miss_hit),
    .hit_tid    (issue_tid),
    .miss_valid (miss_valid),
    .miss_tid   (miss_tid)
  );

endmodule

// File: rtl/dtu_checker.sv
module dtu_checker
  import dtu_pkg::*;
#(
  parameter int THREADS = 6,
  parameter int TIMER_W = 32
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       issue_valid,
  input logic [1:0]                 issue_kind,
  input logic [TIMER_W-1:0]         issue_value,
  input logic                       stall,
  input logic                       miss_valid,
  input logic [THREADS-1:0]         load_vec,
  input logic [THREADS*TIMER_W-1:0] timers
);

  // R2: a stall is only ever raised for an issued wait instruction
  assert_stall_needs_wait_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (issue_valid && issue_kind == KIND_WAIT));

  // R6: a miss report always follows a branch-on-miss issue
  assert_miss_after_branch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    miss_valid |-> $past(issue_valid && issue_kind == KIND_BRANCH));

  // R11: no more than one timer written per cycle
  assert_single_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(load_vec));

  for (genvar t = 0; t < THREADS; t++) begin : g_chk
    // R8: a written timer holds the value that was carried in
    assert_load_value_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(load_vec[t]) |-> timers[t*TIMER_W +: TIMER_W] == $past(issue_value));

    // R4: an unwritten running timer steps down by one
    assert_countdown_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(load_vec[t]) && $past(timers[t*TIMER_W +: TIMER_W]) != '0)
        |-> timers[t*TIMER_W +: TIMER_W] == $past(timers[t*TIMER_W +: TIMER_W]) - TIMER_W'(1));

    // R5: an unwritten expired timer stays at zero
    assert_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(load_vec[t]) && $past(timers[t*TIMER_W +: TIMER_W]) == '0)
        |-> timers[t*TIMER_W +: TIMER_W] == '0);
  end

endmodule

bind deadline_timer_unit dtu_checker #(
  .THREADS (THREADS),
  .TIMER_W (TIMER_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .issue_valid (issue_valid),
  .issue_kind  (issue_kind),
  .issue_value (issue_value),
  .stall       (stall),
  .miss_valid  (miss_valid),
  .load_vec    (load_vec),
  .timers      (timer_flat)
);

// File: tb/deadline_timer_unit_test.sv
`timescale 1ns/1ps
module deadline_timer_unit_test;

  localparam int NT = 6;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        issue_valid;
  logic [2:0]  issue_tid;
  logic [1:0]  issue_kind;
  logic [31:0] issue_value;
  logic        stall;
  logic        miss_valid;
  logic [2:0]  miss_tid;

  int    n_checks = 0;
  int    n_errors = 0;
  longint cyc = 0;

  longint mdl_val [NT];
  longint mdl_lc  [NT];

  deadline_timer_unit uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue_valid (issue_valid),
    .issue_tid   (issue_tid),
    .issue_kind  (issue_kind),
    .issue_value (issue_value),
    .stall       (stall),
    .miss_valid  (miss_valid),
    .miss_tid    (miss_tid)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  function automatic longint remaining(input int t, input longint w);
    longint r;
    r = mdl_val[t] - (w - mdl_lc[t]);
    return (r < 0) ? 0 : r;
  endfunction

  // issue one instruction, replaying while stalled; checks stall count and miss pulse
  task automatic issue_op(input int kind, input int tid, input longint val, input string req);
    int     n = 0;
    longint w0 = 0, w = 0, exp_n;
    bit     first = 1'b1, exp_miss, live;
    live = (tid < NT);
    forever begin
      @(negedge clk);
      issue_valid = 1'b1;
      issue_kind  = 2'(kind);
      issue_tid   = 3'(tid);
      issue_value = 32'(val);
      #1;
      w = cyc;
      if (first) begin w0 = w; first = 1'b0; end
      if (!stall || n > 5000) break;
      n++;
    end
    exp_n    = (kind == 0 && live) ? remaining(tid, w0) : 0;
    check(n == exp_n, req, n, exp_n);
    exp_miss = (kind == 1 && live && remaining(tid, w) == 0);
    if (live && kind != 3) begin
      mdl_val[tid] = val;
      mdl_lc[tid]  = w + 1;
    end
    @(negedge clk);
    issue_valid = 1'b0;
    #1;
    check(miss_valid == exp_miss, (kind == 1) ? "R6" : "R8", miss_valid, exp_miss);
    if (exp_miss) check(miss_tid == 3'(tid), "R6", miss_tid, tid);
    @(negedge clk);
    #1;
    check(miss_valid == 1'b0, "R10", miss_valid, 0);
  endtask

  task automatic idle(input int g);
    repeat (g) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=running expected=done");
    finish_run();
  end

  initial begin
    rst_n       = 1'b0;
    issue_valid = 1'b0;
    issue_tid   = '0;
    issue_kind  = '0;
    issue_value = '0;
    for (int t = 0; t < NT; t++) begin mdl_val[t] = 0; mdl_lc[t] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(stall == 1'b0, "R1", stall, 0);
    check(miss_valid == 1'b0, "R1", miss_valid, 0);

    // R1 first wait per thread is free, R3 it loads the carried value
    for (int t = 0; t < NT; t++) issue_op(0, t, 7 + 2 * t, "R1");
    // R2 / R4: drain each thread in reverse order, counts from the model
    for (int t = NT - 1; t >= 0; t--) issue_op(0, t, 0, "R2");
    // R3: the previous wait loaded zero, so this wait is free
    issue_op(0, 2, 5, "R3");

    // R2 / R8: gap sweep after a load instruction
    foreach (mdl_val[t]) begin
      for (int g = 0; g < 13; g += 3) begin
        issue_op(2, t, 9, "R8");
        idle(g);
        issue_op(0, t, 0, "R2");
      end
    end

    // R7: branch on a running timer replaces the count
    issue_op(2, 2, 5, "R8");
    issue_op(1, 2, 30, "R7");
    issue_op(0, 2, 0, "R7");
    // R6: branch on an expired timer reports a miss and loads
    idle(40);
    issue_op(1, 2, 4, "R6");
    issue_op(0, 2, 0, "R6");

    // R5: long idle leaves the timer at zero, not wrapped
    issue_op(2, 4, 3, "R8");
    idle(60);
    check(remaining(4, cyc) == 0, "R5", remaining(4, cyc), 0);
    issue_op(0, 4, 0, "R5");
    issue_op(1, 4, 0, "R5");

    // R9: reserved kind leaves the timer untouched
    issue_op(2, 1, 20, "R8");
    issue_op(3, 1, 2, "R9");
    issue_op(0, 1, 0, "R9");

    // R11: out-of-range thread numbers do nothing
    issue_op(2, 5, 15, "R8");
    issue_op(2, 6, 1, "R11");
    issue_op(0, 7, 9, "R11");
    issue_op(1, 7, 9, "R11");
    issue_op(0, 5, 0, "R11");

    // R8: full-width value overwritten before it matters
    issue_op(2, 0, 64'hFFFF_FFF0, "R8");
    issue_op(2, 0, 6, "R8");
    issue_op(0, 0, 0, "R8");

    finish_run();
  end

endmodule